// File: doc/BRIEF.md
# I/O Port and Interrupt-Controller Page Redirector

This block sits after address translation and decides where each request finally goes. An I/O-space request carries a 16-bit port number and an access size in bytes. The block sorts I/O requests into three kinds. The first is a 4-byte access to the configuration-address port, which selects a register held inside the block. The second is an access to one of the four configuration-data ports. When enabled, that access becomes a configuration-space address built from the stored register. Every other port is mapped into a flat I/O window.

A memory request carries a physical address. If that address lands in the single 4 KiB page holding the local interrupt controller, the block moves it into a per-CPU window and marks it uncacheable. Any other memory address passes through unchanged.

The routing is purely combinational. The only state is the 32-bit configuration-address register. That register is loaded by a 4-byte write to the configuration-address port, and a 4-byte read of that port returns it locally.

Top module: `ioport_apic_redirect`

## Requirements
- R1: An I/O access to port 0xCF8 with size 4 raises `out_int_reg` and drives `out_addr` to the parameter `CFG_REG_ADDR`. When it is a read, `out_rdata_vld` is 1 and `out_rdata` holds the configuration-address register.
- R2: The configuration-address register resets to 0. It loads `req_wdata` on the clock edge that ends a valid 4-byte I/O write to port 0xCF8. At all other times it keeps its value.
- R3: When bit 31 of the configuration-address register is 1, an I/O access to ports 0xCFC through 0xCFF drives `out_addr` to `CFG_PREFIX` OR (register AND 0x7FFFFFFC) OR (port AND 3). In that case `out_no_target` is 0.
- R4: When bit 31 of the configuration-address register is 0, an access to ports 0xCFC through 0xCFF raises `out_no_target` and drives `out_addr` to 0. For a read, `out_rdata_vld` is 1 and `out_rdata` is 0xFFFFFFFF.
- R5: Every other I/O port maps to `IO_PREFIX` OR port, with no flag raised. This includes port 0xCF8 at a size other than 4 and ports 0xCF9 through 0xCFB. A write of this kind leaves the register unchanged.
- R6: A memory address whose bits above `PAGE_SHIFT` equal `apic_base_pfn` raises `out_uncacheable`. It drives `out_addr` to `WIN_PREFIX` OR (`cpu_id` shifted left by `PAGE_SHIFT`) OR the page offset.
- R7: Any other memory address appears unchanged on `out_addr`, with every flag at 0. This includes the addresses one byte before and one byte after the interrupt-controller page.
- R8: At most one of `out_int_reg`, `out_no_target` and `out_uncacheable` is 1. While `req_valid` is 0, all outputs are 0 and no register write happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration-address register |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_is_io | input | 1 | 1 for I/O space, 0 for memory |
| req_write | input | 1 | 1 for a write |
| req_size | input | SZ_W (4) | Access size in bytes |
| req_port | input | 16 | I/O port number |
| req_paddr | input | PA_W (40) | Physical address of a memory request |
| req_wdata | input | 32 | Write data |
| apic_base_pfn | input | PA_W-PAGE_SHIFT (28) | Page number of the interrupt-controller page |
| cpu_id | input | CPU_W (4) | Identifier that selects the per-CPU window |
| out_addr | output | PA_W (40) | Redirected address |
| out_int_reg | output | 1 | Request targets the internal configuration-address register |
| out_no_target | output | 1 | Configuration data access while disabled; request is dropped |
| out_uncacheable | output | 1 | Request must bypass caches |
| out_rdata_vld | output | 1 | Block supplies the read data itself |
| out_rdata | output | 32 | Locally supplied read data |

## Verification
On every cycle the assertions check the following. Flags never overlap, and an idle request produces all-zero outputs. A dropped access only occurs while the enable bit is clear. Every redirected window address keeps the page offset, and the register-select path always points at the fixed internal address. They also check that the register loads exactly on a qualifying write and otherwise holds. Only the bench scenarios can show that the full configuration-space address carries the right register bits and port bits. The same goes for the exact window address and its page boundaries, and for a sub-4-byte access to 0xCF8 leaving the register untouched. Those scenarios compare every output against a separate model across random traffic.

// File: rtl/redir_pkg.sv
package redir_pkg;
  localparam logic [15:0] PORT_CFG_ADDR = 16'h0CF8;
  localparam logic [13:0] PORT_CFG_DATA_HI = 14'h033F; // 0xCFC >> 2

  typedef enum logic [1:0] {
    IOC_PLAIN    = 2'd0,
    IOC_CFG_REG  = 2'd1,
    IOC_CFG_DATA = 2'd2
  } io_class_e;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else if (wr_en) value <= wr_data;
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> value == $past(wr_data));
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(value));
endmodule

// File: rtl/io_port_map.sv
module io_port_map
  import redir_pkg::*;
#(
  parameter int PA_W = 40,
  parameter int SZ_W = 4,
  parameter logic [PA_W-1:0] IO_PREFIX    = 40'h20_0000_0000,
  parameter logic [PA_W-1:0] CFG_PREFIX   = 40'h30_0000_0000,
  parameter logic [PA_W-1:0] CFG_REG_ADDR = 40'h10_0000_0000
) (
  input  logic [15:0]     port,
  input  logic [SZ_W-1:0] size,
  input  logic            cfg_en,
  input  logic [30:2]     cfg_sel,
  output io_class_e       cls,
  output logic [PA_W-1:0] addr,
  output logic            no_target
);
  localparam int PAD_W = PA_W - 32;

  function automatic io_class_e classify(input logic [15:0] p, input logic [SZ_W-1:0] s);
    if (p == PORT_CFG_ADDR && s == SZ_W'(4)) return IOC_CFG_REG;
    if (p[15:2] == PORT_CFG_DATA_HI)         return IOC_CFG_DATA;
    return IOC_PLAIN;
  endfunction

  function automatic logic [PA_W-1:0] cfg_space_addr(input logic [30:2] sel, input logic [1:0] lo);
    return CFG_PREFIX | {{PAD_W{1'b0}}, 1'b0, sel, lo};
  endfunction

  function automatic logic [PA_W-1:0] io_space_addr(input logic [15:0] p);
    return IO_PREFIX | {{(PA_W-16){1'b0}}, p};
  endfunction

  always_comb begin
    cls       = classify(port, size);
    no_target = 1'b0;
    addr      = '0;
    unique case (cls)
      IOC_CFG_REG: addr = CFG_REG_ADDR;
      IOC_CFG_DATA: begin
        if (cfg_en) addr = cfg_space_addr(cfg_sel, port[1:0]);
        else        no_target = 1'b1;
      end
      default: addr = io_space_addr(port);
    endcase
  end
endmodule

// File: rtl/apic_page_map.sv
module apic_page_map #(
  parameter int PA_W       = 40,
  parameter int PAGE_SHIFT = 12,
  parameter int CPU_W      = 4,
  parameter logic [PA_W-1:0] WIN_PREFIX = 40'h40_0000_0000,
  localparam int PFN_W = PA_W - PAGE_SHIFT
) (
  input  logic [PA_W-1:0]  paddr,
  input  logic [PFN_W-1:0] base_pfn,
  input  logic [CPU_W-1:0] cpu_id,
  output logic             hit,
  output logic [PA_W-1:0]  addr
);
  function automatic logic [PA_W-1:0] window_addr(input logic [CPU_W-1:0] id,
                                                  input logic [PAGE_SHIFT-1:0] off);
    logic [PA_W-1:0] cpu_part;
    cpu_part = PA_W'(id) << PAGE_SHIFT;
    return WIN_PREFIX | cpu_part | PA_W'(off);
  endfunction

  always_comb begin
    hit  = (paddr[PA_W-1:PAGE_SHIFT] == base_pfn);
    addr = hit ? window_addr(cpu_id, paddr[PAGE_SHIFT-1:0]) : paddr;
  end
endmodule

// File: rtl/ioport_apic_redirect.sv
module ioport_apic_redirect
  import redir_pkg::*;
#(
  parameter int PA_W       = 40,
  parameter int PAGE_SHIFT = 12,
  parameter int CPU_W      = 4,
  parameter int SZ_W       = 4,
  parameter logic [PA_W-1:0] IO_PREFIX    = 40'h20_0000_0000,
  parameter logic [PA_W-1:0] CFG_PREFIX   = 40'h30_0000_0000,
  parameter logic [PA_W-1:0] WIN_PREFIX   = 40'h40_0000_0000,
  parameter logic [PA_W-1:0] CFG_REG_ADDR = 40'h10_0000_0000
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  input  logic                       req_is_io,
  input  logic                       req_write,
  input  logic [SZ_W-1:0]            req_size,
  input  logic [15:0]                req_port,
  input  logic [PA_W-1:0]            req_paddr,
  input  logic [31:0]                req_wdata,
  input  logic [PA_W-PAGE_SHIFT-1:0] apic_base_pfn,
  input  logic [CPU_W-1:0]           cpu_id,
  output logic [PA_W-1:0]            out_addr,
  output logic                       out_int_reg,
  output logic                       out_no_target,
  output logic                       out_uncacheable,
  output logic                       out_rdata_vld,
  output logic [31:0]                out_rdata
);
  localparam int PFN_W = PA_W - PAGE_SHIFT;

  logic [31:0]     cfg_q;
  logic            cfg_wr;
  io_class_e       io_cls;
  logic [PA_W-1:0] io_addr;
  logic            io_drop;
  logic            mem_hit;
  logic [PA_W-1:0] mem_addr;
  logic            io_req, mem_req;

  assign io_req  = req_valid && req_is_io;
  assign mem_req = req_valid && !req_is_io;
  assign cfg_wr  = io_req && req_write && (io_cls == IOC_CFG_REG);

  cfg_addr_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_data (req_wdata),
    .value   (cfg_q)
  );

  io_port_map #(
    .PA_W(PA_W), .SZ_W(SZ_W), .IO_PREFIX(IO_PREFIX),
    .CFG_PREFIX(CFG_PREFIX), .CFG_REG_ADDR(CFG_REG_ADDR)
  ) u_io (
    .port      (req_port),
    .size      (req_size),
    .cfg_en    (cfg_q[31]),
    .cfg_sel   (cfg_q[30:2]),
    .cls       (io_cls),
    .addr      (io_addr),
    .no_target (io_drop)
  );

  apic_page_map #(
    .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT), .CPU_W(CPU_W), .WIN_PREFIX(WIN_PREFIX)
  ) u_apic (
    .paddr    (req_paddr),
    .base_pfn (apic_base_pfn),
    .cpu_id   (cpu_id),
    .hit      (mem_hit),
    .addr     (mem_addr)
  );

  always_comb begin
    out_addr        = '0;
    out_int_reg     = 1'b0;
    out_no_target   = 1'b0;
    out_uncacheable = 1'b0;
    out_rdata_vld   = 1'b0;
    out_rdata       = '0;
    if (io_req) begin
      out_addr      = io_addr;
      out_int_reg   = (io_cls == IOC_CFG_REG);
      out_no_target = io_drop;
      if (!req_write && out_int_reg) begin
        out_rdata_vld = 1'b1;
        out_rdata     = cfg_q;
      end else if (!req_write && io_drop) begin
        out_rdata_vld = 1'b1;
        out_rdata     = '1;
      end
    end else if (mem_req) begin
      out_addr        = mem_addr;
      out_uncacheable = mem_hit;
    end
  end

  assert_regsel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && req_port == 16'h0CF8 && req_size == SZ_W'(4))
      |-> (out_int_reg && out_addr == CFG_REG_ADDR));
  assert_cfgdata_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && req_port[15:2] == PORT_CFG_DATA_HI && cfg_q[31])
      |-> (!out_no_target && out_addr[PA_W-1:32] == CFG_PREFIX[PA_W-1:32]
           && out_addr[1:0] == req_port[1:0]));
  assert_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_no_target |-> (!cfg_q[31] && out_addr == '0));
  assert_uc_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_uncacheable |-> (!req_is_io
      && out_addr[PAGE_SHIFT-1:0] == req_paddr[PAGE_SHIFT-1:0]
      && req_paddr[PA_W-1:PAGE_SHIFT] == PFN_W'(apic_base_pfn)));
  assert_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_int_reg, out_no_target, out_uncacheable}));
  assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (out_addr == '0 && !out_int_reg && !out_no_target
                    && !out_uncacheable && !out_rdata_vld));
endmodule

// File: tb/sim_ioport_apic_redirect.sv
module sim_ioport_apic_redirect;
  localparam logic [39:0] P_IO  = 40'h20_0000_0000;
  localparam logic [39:0] P_CFG = 40'h30_0000_0000;
  localparam logic [39:0] P_WIN = 40'h40_0000_0000;
  localparam logic [39:0] P_REG = 40'h10_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_is_io = 1'b0, req_write = 1'b0;
  logic [3:0]  req_size = '0;
  logic [15:0] req_port = '0;
  logic [39:0] req_paddr = '0;
  logic [31:0] req_wdata = '0;
  logic [27:0] apic_base_pfn = 28'h00FEE;
  logic [3:0]  cpu_id = 4'h5;
  logic [39:0] out_addr;
  logic        out_int_reg, out_no_target, out_uncacheable, out_rdata_vld;
  logic [31:0] out_rdata;

  int n_run = 0, n_fail = 0;
  logic [31:0] model_cfg = '0;

  always #4 clk = ~clk;

  ioport_apic_redirect u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_io(req_is_io),
    .req_write(req_write), .req_size(req_size), .req_port(req_port),
    .req_paddr(req_paddr), .req_wdata(req_wdata), .apic_base_pfn(apic_base_pfn),
    .cpu_id(cpu_id), .out_addr(out_addr), .out_int_reg(out_int_reg),
    .out_no_target(out_no_target), .out_uncacheable(out_uncacheable),
    .out_rdata_vld(out_rdata_vld), .out_rdata(out_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected record: {addr, int_reg, no_target, uc, rvld, rdata}
  task automatic expect_all(input string req, input logic [39:0] ea, input bit ei, input bit en,
                            input bit eu, input bit ev, input logic [31:0] ed);
    chk(out_addr == ea, {req, " addr"}, 64'(out_addr), 64'(ea));
    chk({out_int_reg, out_no_target, out_uncacheable} == {ei, en, eu}, {req, " flags"},
        64'({out_int_reg, out_no_target, out_uncacheable}), 64'({ei, en, eu}));
    chk(out_rdata_vld == ev && (!ev || out_rdata == ed), {req, " rdata"},
        64'({out_rdata_vld, out_rdata}), 64'({ev, ed}));
  endtask

  // Independent model of the routing rules
  task automatic predict_check(input string req);
    logic [39:0] ea; bit ei, en, eu, ev; logic [31:0] ed;
    ea = '0; ei = 0; en = 0; eu = 0; ev = 0; ed = '0;
    if (!req_valid) begin
    end else if (req_is_io) begin
      if (req_port == 16'hCF8 && req_size == 4'd4) begin
        ea = P_REG; ei = 1; ev = !req_write; ed = model_cfg;
      end else if (req_port >= 16'hCFC && req_port <= 16'hCFF) begin
        if (model_cfg[31]) ea = P_CFG + 40'(model_cfg & 32'h7FFF_FFFC) + 40'(req_port - 16'hCFC);
        else begin en = 1; ev = !req_write; ed = 32'hFFFF_FFFF; end
      end else ea = P_IO + 40'(req_port);
    end else begin
      logic [39:0] lo;
      lo = {apic_base_pfn, 12'h000};
      if (req_paddr >= lo && req_paddr < lo + 40'h1000) begin
        eu = 1; ea = P_WIN + 40'(cpu_id) * 40'h1000 + (req_paddr - lo);
      end else ea = req_paddr;
    end
    expect_all(req, ea, ei, en, eu, ev, ed);
  endtask

  task automatic io_op(input string req, input bit wr, input logic [3:0] sz,
                       input logic [15:0] p, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_is_io = 1; req_write = wr; req_size = sz; req_port = p; req_wdata = d;
    #1 predict_check(req);
    if (wr && p == 16'hCF8 && sz == 4'd4) model_cfg = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic mem_op(input string req, input logic [39:0] a);
    @(negedge clk);
    req_valid = 1; req_is_io = 0; req_write = 0; req_paddr = a;
    #1 predict_check(req);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1 predict_check("R8 idle");
    // reset value readback
    io_op("R1 R2 reset read", 0, 4'd4, 16'hCF8, 0);
    io_op("R4 disabled data read", 0, 4'd4, 16'hCFC, 0);
    io_op("R4 disabled data write", 1, 4'd1, 16'hCFE, 32'h12);
    io_op("R5 cf8 size2 write", 1, 4'd2, 16'hCF8, 32'hFFFF_FFFF);
    io_op("R5 r2_no_load readback", 0, 4'd4, 16'hCF8, 0);
    io_op("R2 load enable", 1, 4'd4, 16'hCF8, 32'h8012_3457);
    io_op("R1 readback", 0, 4'd4, 16'hCF8, 0);
    for (int p = 16'hCFC; p <= 16'hCFF; p++) io_op("R3 data port", 0, 4'd1, 16'(p), 0);
    io_op("R5 port cf9", 0, 4'd1, 16'hCF9, 0);
    io_op("R5 port cfb", 0, 4'd1, 16'hCFB, 0);
    io_op("R5 cf8 size1", 0, 4'd1, 16'hCF8, 0);
    io_op("R5 port ffff", 0, 4'd2, 16'hFFFF, 0);
    mem_op("R7 page-1", 40'h0000_FEDF_FF);
    mem_op("R6 page start", 40'h0000_FEE0_00);
    mem_op("R6 page end", 40'h0000_FEE0_FF + 40'hF00);
    mem_op("R7 page+1", 40'h0000_FEF0_00);
    // random mix
    for (int i = 0; i < 400; i++) begin
      int k; logic [3:0] sz; logic [15:0] p;
      k = $urandom_range(0, 9);
      sz = (k % 3 == 0) ? 4'd4 : ((k % 3 == 1) ? 4'd2 : 4'd1);
      if (i % 50 == 0) begin
        apic_base_pfn = 28'($urandom); cpu_id = 4'($urandom);
      end
      if (k < 2) io_op("R1 R2 rnd cf8", $urandom_range(0, 1), sz, 16'hCF8,
                       $urandom);
      else if (k < 4) io_op("R3 R4 rnd data", $urandom_range(0, 1), sz,
                            16'hCFC + 16'($urandom_range(0, 3)), 0);
      else if (k < 6) begin
        p = 16'($urandom);
        io_op("R5 rnd port", $urandom_range(0, 1), sz, p, $urandom);
      end else if (k < 8) mem_op("R6 rnd in-page",
                                 {apic_base_pfn, 12'($urandom)});
      else mem_op("R7 rnd mem", {8'($urandom), 32'($urandom)});
    end
    @(negedge clk);
    #1 predict_check("R8 idle end");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule